// File: doc/BRIEF.md
# Sector Bit-Flip Corrector for BCH Decode Results

This block finishes the correction of one 512-byte flash sector after an external BCH decoder has located the bad bits. It owns a byte-wide local RAM holding the sector. A host loads the raw sector through a simple byte port. It then presents the decoder's result: a status word and four packed words of bit positions. The block walks the reported positions in index order and inverts each addressed bit with a read, XOR, write sequence. It ends with a one-cycle completion pulse that carries either the number of corrected bits or a failure flag.

Two flags in the status word decide the path. If no error was found, nothing is touched. If the decoder gave up, the block reports failure and touches nothing. A strength input selects 4-bit or 8-bit correction. An error count above the selected strength is treated as a failure. Positions that land past the data area, in the parity bytes, are skipped without a write. They still count toward the reported total. The host reads the corrected sector back through the same byte port once the block is idle.

Top module: `bch_flip_fix`

## Requirements
- R1: After reset, busy, done, done_fail are 0 and done_count is 0.
- R2: Position word k (dec_pos_words bits 32k+31:32k) holds position 2k in its bits 12:0 and position 2k+1 in its bits 28:16. Position p inverts bit p[2:0] of byte p[11:3].
- R3: The status word has bit 0 = uncorrectable, bit 1 = errors found, and bits 7:4 = error count. With bit 1 clear, the result is done_count 0 and done_fail 0, and the buffer is unchanged, whatever bit 0 holds.
- R4: With bits 1 and 0 both set, the result is done_fail 1 and done_count 0, and no bit of the buffer changes.
- R5: Only positions 0 to count-1 are applied, in index order. Positions at or beyond the count leave the buffer untouched.
- R6: A position of 4096 or more is not applied, but it is included in done_count. On success, done_count equals the status count.
- R7: When strength8 is 0 the limit is 4; when it is 1 the limit is 8. A count above the limit gives done_fail 1, done_count 0 and no change to the buffer.
- R8: done is a one-cycle pulse. busy rises in the cycle after dec_valid is accepted while idle and stays high through the done cycle. A dec_valid seen while busy is ignored.
- R9: A host byte access with host_en gives read data on host_rdata one cycle later. A host write is dropped while busy is high.
- R10: Positions are applied one after another. Two positions in the same byte both take effect, and a position reported twice leaves its bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strength8 | input | 1 | 1 selects 8-bit strength, 0 selects 4-bit |
| dec_valid | input | 1 | Decode result strobe |
| dec_status | input | 8 | Decode status word |
| dec_pos_words | input | 128 | Four packed position words |
| busy | output | 1 | Correction in progress |
| done | output | 1 | One-cycle completion pulse |
| done_fail | output | 1 | Sector uncorrectable, valid with done |
| done_count | output | 4 | Number of corrected bits, valid with done |
| host_en | input | 1 | Host byte access enable |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 9 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one cycle after the read |

## Verification
The hardest situation to reach from the ports is a stimulus arriving in the middle of a correction. That covers a second decode strobe and a host write landing while the block holds the RAM. The bench starts a full eight-position correction, which keeps the block busy for about two dozen cycles. During that window it fires a competing decode that would flip a bit, and a host write to a known byte. It then compares the whole sector with a model that applies only the first job. Duplicate and same-byte positions, and positions in the parity region, are placed in the same eight-position jobs. This exercises the sequential read-modify-write ordering.

// File: rtl/bchfix_pkg.sv
package bchfix_pkg;
  localparam int SECT_BYTES = 512;
  localparam int BYTE_W     = 8;
  localparam int POS_W      = 13;
  localparam int MAX_POS    = 8;
  localparam int CNT_W      = 4;
  localparam int WORD_W     = 32;
  localparam int HI_LSB     = 16;
  localparam int NWORDS     = MAX_POS / 2;
  localparam int ST_UNC     = 0;
  localparam int ST_FOUND   = 1;
  localparam int ST_CNT_LSB = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_EVAL, S_STEP, S_RD, S_WR, S_FIN
  } fix_state_t;
endpackage

// File: rtl/bchfix_pos_unpack.sv
module bchfix_pos_unpack #(
  parameter int POS_W   = 13,
  parameter int WORD_W  = 32,
  parameter int HI_LSB  = 16,
  parameter int NWORDS  = 4
) (
  input  logic [NWORDS*WORD_W-1:0]  words,
  output logic [2*NWORDS*POS_W-1:0] pos_flat
);
  logic [NWORDS-1:0] unused_gap;

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    assign pos_flat[(2*k)*POS_W +: POS_W]   = words[k*WORD_W +: POS_W];
    assign pos_flat[(2*k+1)*POS_W +: POS_W] = words[k*WORD_W+HI_LSB +: POS_W];
    assign unused_gap[k] = ^{words[k*WORD_W+POS_W +: HI_LSB-POS_W],
                             words[k*WORD_W+HI_LSB+POS_W +: WORD_W-HI_LSB-POS_W]};
  end
endmodule

// File: rtl/bchfix_sector_ram.sv
module bchfix_sector_ram #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/bchfix_engine.sv
module bchfix_engine
  import bchfix_pkg::*;
#(
  parameter int SECT  = 512,
  parameter int DW    = 8,
  parameter int PW    = 13,
  parameter int NPOS  = 8,
  parameter int CW    = 4,
  localparam int AW    = $clog2(SECT),
  localparam int BITW  = $clog2(DW),
  localparam int IDXW  = $clog2(NPOS),
  localparam int DBITS = SECT * DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_req,
  input  logic               st_unc,
  input  logic               st_found,
  input  logic [CW-1:0]      st_cnt,
  input  logic               strength8,
  input  logic [NPOS*PW-1:0] pos_flat,
  output logic               busy,
  output logic               done,
  output logic               done_fail,
  output logic [CW-1:0]      done_count,
  output logic               ram_en,
  output logic               ram_we,
  output logic [AW-1:0]      ram_addr,
  output logic [DW-1:0]      ram_wdata,
  input  logic [DW-1:0]      ram_rdata
);
  localparam logic [CW-1:0] LIM8  = CW'(NPOS);
  localparam logic [CW-1:0] LIM4  = CW'(NPOS / 2);
  localparam logic [PW:0]   PLIM  = (PW+1)'(DBITS);

  fix_state_t    state_q, state_d;
  logic [CW-1:0] idx_q, idx_d;
  logic [CW-1:0] cnt_q;
  logic          unc_q, found_q, s8_q;
  logic          fail_q, fail_d;
  logic [CW-1:0] count_q, count_d;
  logic [PW-1:0] pos_q [NPOS];
  logic          cap_en;
  logic [PW-1:0] cur_pos;
  logic [CW-1:0] lim;
  logic          in_data;

  assign cap_en  = (state_q == S_IDLE) && start_req;
  assign cur_pos = pos_q[idx_q[IDXW-1:0]];
  assign lim     = s8_q ? LIM8 : LIM4;
  assign in_data = {1'b0, cur_pos} < PLIM;

  // next-state process
  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    fail_d    = fail_q;
    count_d   = count_q;
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = cur_pos[AW+BITW-1:BITW];
    ram_wdata = ram_rdata ^ (DW'(1) << cur_pos[BITW-1:0]);
    unique case (state_q)
      S_IDLE: if (start_req) state_d = S_EVAL;
      S_EVAL: begin
        if (!found_q) begin
          fail_d = 1'b0; count_d = '0; state_d = S_FIN;
        end else if (unc_q || (cnt_q > lim)) begin
          fail_d = 1'b1; count_d = '0; state_d = S_FIN;
        end else begin
          fail_d = 1'b0; count_d = cnt_q; idx_d = '0; state_d = S_STEP;
        end
      end
      S_STEP: begin
        if (idx_q == cnt_q)  state_d = S_FIN;
        else if (in_data)    state_d = S_RD;
        else                 idx_d   = idx_q + 1'b1;
      end
      S_RD: begin
        ram_en  = 1'b1;
        state_d = S_WR;
      end
      S_WR: begin
        ram_en  = 1'b1;
        ram_we  = 1'b1;
        idx_d   = idx_q + 1'b1;
        state_d = S_STEP;
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      fail_q  <= 1'b0;
      count_q <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      fail_q  <= fail_d;
      count_q <= count_d;
    end
  end

  // job capture registers, enabled on acceptance
  always_ff @(posedge clk) begin
    if (cap_en) begin
      unc_q   <= st_unc;
      found_q <= st_found;
      cnt_q   <= st_cnt;
      s8_q    <= strength8;
      for (int k = 0; k < NPOS; k++) pos_q[k] <= pos_flat[k*PW +: PW];
    end
  end

  assign busy       = (state_q != S_IDLE);
  assign done       = (state_q == S_FIN);
  assign done_fail  = fail_q;
  assign done_count = count_q;
endmodule

// File: rtl/bch_flip_fix.sv
module bch_flip_fix
  import bchfix_pkg::*;
#(
  parameter int SECT  = SECT_BYTES,
  parameter int DW    = BYTE_W,
  parameter int PW    = POS_W,
  parameter int NPOS  = MAX_POS,
  parameter int CW    = CNT_W,
  parameter int WW    = WORD_W,
  localparam int AW   = $clog2(SECT),
  localparam int NW   = NPOS / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strength8,
  input  logic            dec_valid,
  input  logic [7:0]      dec_status,
  input  logic [NW*WW-1:0] dec_pos_words,
  output logic            busy,
  output logic            done,
  output logic            done_fail,
  output logic [CW-1:0]   done_count,
  input  logic            host_en,
  input  logic            host_we,
  input  logic [AW-1:0]   host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata
);
  logic rs_meta_q, rs_q;
  logic [NPOS*PW-1:0] pos_flat;
  logic          eng_en, eng_we;
  logic [AW-1:0] eng_addr;
  logic [DW-1:0] eng_wdata;
  logic          ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_rdata;
  logic          unused_status_bits;

  assign unused_status_bits = ^dec_status[ST_CNT_LSB-1:ST_FOUND+1];

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end

  bchfix_pos_unpack #(.POS_W(PW), .WORD_W(WW), .HI_LSB(HI_LSB), .NWORDS(NW)) u_unpack (
    .words    (dec_pos_words),
    .pos_flat (pos_flat)
  );

  bchfix_engine #(.SECT(SECT), .DW(DW), .PW(PW), .NPOS(NPOS), .CW(CW)) u_eng (
    .clk        (clk),
    .rst_n      (rs_q),
    .start_req  (dec_valid),
    .st_unc     (dec_status[ST_UNC]),
    .st_found   (dec_status[ST_FOUND]),
    .st_cnt     (dec_status[ST_CNT_LSB +: CW]),
    .strength8  (strength8),
    .pos_flat   (pos_flat),
    .busy       (busy),
    .done       (done),
    .done_fail  (done_fail),
    .done_count (done_count),
    .ram_en     (eng_en),
    .ram_we     (eng_we),
    .ram_addr   (eng_addr),
    .ram_wdata  (eng_wdata),
    .ram_rdata  (ram_rdata)
  );

  // engine owns the RAM while busy; host accesses are dropped then
  always_comb begin
    if (busy) begin
      ram_en    = eng_en;
      ram_we    = eng_we;
      ram_addr  = eng_addr;
      ram_wdata = eng_wdata;
    end else begin
      ram_en    = host_en;
      ram_we    = host_we;
      ram_addr  = host_addr;
      ram_wdata = host_wdata;
    end
  end

  bchfix_sector_ram #(.DEPTH(SECT), .DW(DW)) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  assign host_rdata = ram_rdata;
endmodule

// File: rtl/bch_flip_fix_chk.sv
module bch_flip_fix_chk #(
  parameter int CW   = 4,
  parameter int NPOS = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dec_valid,
  input logic          busy,
  input logic          done,
  input logic          done_fail,
  input logic [CW-1:0] done_count,
  input logic          ram_en,
  input logic          ram_we
);
  logic [CW:0] wr_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   wr_cnt_q <= '0;
    else if (dec_valid && !busy)  wr_cnt_q <= '0;
    else if (busy && ram_en && ram_we) wr_cnt_q <= wr_cnt_q + 1'b1;
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !busy) |=> busy);

  p_fail_no_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fail) |-> (wr_cnt_q == '0));

  p_fail_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fail) |-> (done_count == '0));

  p_flip_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_cnt_q <= {1'b0, done_count}));

  p_count_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_count <= CW'(NPOS)));
endmodule

bind bch_flip_fix bch_flip_fix_chk #(.CW(CW), .NPOS(NPOS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dec_valid  (dec_valid),
  .busy       (busy),
  .done       (done),
  .done_fail  (done_fail),
  .done_count (done_count),
  .ram_en     (ram_en),
  .ram_we     (ram_we)
);

// File: tb/sim_bch_flip_fix.sv
module sim_bch_flip_fix;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 512;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         strength8 = 1'b0;
  logic         dec_valid = 1'b0;
  logic [7:0]   dec_status = '0;
  logic [127:0] dec_pos_words = '0;
  logic         busy, done, done_fail;
  logic [3:0]   done_count;
  logic         host_en = 1'b0, host_we = 1'b0;
  logic [8:0]   host_addr = '0;
  logic [7:0]   host_wdata = '0;
  logic [7:0]   host_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0]  exp_mem [NB];
  logic [12:0] pos_set [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  bch_flip_fix u0 (
    .clk(clk), .rst_n(rst_n), .strength8(strength8), .dec_valid(dec_valid),
    .dec_status(dec_status), .dec_pos_words(dec_pos_words), .busy(busy),
    .done(done), .done_fail(done_fail), .done_count(done_count),
    .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, got %0d cycles expected under 150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(logic [8:0] a, logic [7:0] d);
    host_en = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_rd(logic [8:0] a, output logic [7:0] d);
    host_en = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    d = host_rdata;
    host_en = 1'b0;
  endtask

  task automatic cmp_buf(string tag);
    int bad = 0;
    logic [7:0] d;
    logic [7:0] fa = 0, fe = 0;
    for (int a = 0; a < NB; a++) begin
      host_rd(9'(a), d);
      if (d !== exp_mem[a]) begin
        if (bad == 0) begin fa = d; fe = exp_mem[a]; end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s buffer: %0d bytes differ, first actual %0h expected %0h", tag, bad, fa, fe);
    end
  endtask

  function automatic logic [127:0] pack_pos();
    logic [127:0] w = '0;
    for (int k = 0; k < 4; k++) begin
      w[k*32 +: 13]      = pos_set[2*k];
      w[k*32 + 16 +: 13] = pos_set[2*k+1];
      w[k*32 + 13 +: 3]  = 3'b101;
      w[k*32 + 29 +: 3]  = 3'b011;
    end
    return w;
  endfunction

  // expected result from the requirements (R3..R7, R10)
  task automatic model(logic [7:0] st, logic s8, output logic ef, output logic [3:0] ec);
    int lim = s8 ? 8 : 4;
    ef = 1'b0; ec = 4'd0;
    if (!st[1]) return;
    if (st[0] || int'(st[7:4]) > lim) begin ef = 1'b1; return; end
    ec = st[7:4];
    for (int i = 0; i < int'(st[7:4]); i++)
      if (pos_set[i] < 13'd4096)
        exp_mem[pos_set[i][11:3]][pos_set[i][2:0]] ^= 1'b1;
  endtask

  task automatic run_case(string tag, logic [7:0] st, logic s8, bit interfere);
    logic ef;
    logic [3:0] ec;
    logic gf;
    logic [3:0] gc;
    int n = 0;
    model(st, s8, ef, ec);
    strength8 = s8; dec_status = st; dec_pos_words = pack_pos(); dec_valid = 1'b1;
    @(negedge clk);
    dec_valid = 1'b0;
    check({tag, " R8 busy after accept"}, 32'(busy), 32'd1);
    if (interfere) begin
      dec_status = 8'h12; dec_pos_words = 128'h7; dec_valid = 1'b1;
      @(negedge clk);
      dec_valid = 1'b0;
      host_wr(9'd100, 8'hFF);
      check({tag, " R8 still busy"}, 32'(busy), 32'd1);
    end
    while (!done && n < 1000) begin @(negedge clk); n++; end
    gf = done_fail; gc = done_count;
    check({tag, " R8 done seen"}, 32'(done), 32'd1);
    check({tag, " fail flag"}, 32'(gf), 32'(ef));
    check({tag, " count"}, 32'(gc), 32'(ec));
    @(negedge clk);
    check({tag, " R8 done one cycle"}, 32'(done), 32'd0);
    check({tag, " R8 idle after done"}, 32'(busy), 32'd0);
    cmp_buf(tag);
  endtask

  task automatic set_pos(int a0, int a1, int a2, int a3, int a4, int a5, int a6, int a7);
    pos_set[0] = 13'(a0); pos_set[1] = 13'(a1); pos_set[2] = 13'(a2); pos_set[3] = 13'(a3);
    pos_set[4] = 13'(a4); pos_set[5] = 13'(a5); pos_set[6] = 13'(a6); pos_set[7] = 13'(a7);
  endtask

  task automatic t_reset();
    check("R1 busy", 32'(busy), 0);
    check("R1 done", 32'(done), 0);
    check("R1 done_fail", 32'(done_fail), 0);
    check("R1 done_count", 32'(done_count), 0);
  endtask

  task automatic t_fill();
    logic [7:0] d;
    for (int a = 0; a < NB; a++) begin
      exp_mem[a] = 8'(a) ^ 8'h5A ^ 8'(a >> 8);
      host_wr(9'(a), exp_mem[a]);
    end
    host_rd(9'd3, d);
    check("R9 read latency", 32'(d), 32'(exp_mem[3]));
    cmp_buf("R9 fill");
  endtask

  task automatic t_no_errors();
    set_pos(0, 1, 2, 3, 4, 5, 6, 7);
    run_case("R3 found clear", 8'h30, 1'b1, 1'b0);
    run_case("R3 found clear unc set", 8'h31, 1'b1, 1'b0);
  endtask

  task automatic t_uncorrectable();
    set_pos(8, 9, 10, 11, 12, 13, 14, 15);
    run_case("R4 uncorrectable", 8'h33, 1'b1, 1'b0);
  endtask

  task automatic t_mode4();
    set_pos(0, 4095, 13, 1000, 20, 21, 22, 23);
    run_case("R2 R5 mode4 count4", 8'h42, 1'b0, 1'b0);
    run_case("R7 mode4 count5", 8'h52, 1'b0, 1'b0);
  endtask

  task automatic t_mode8();
    set_pos(40, 41, 4096, 8191, 500, 500, 2047, 47);
    run_case("R6 R10 mode8 count8", 8'h82, 1'b1, 1'b0);
    run_case("R7 mode8 count9", 8'h92, 1'b1, 1'b0);
    set_pos(64, 72, 80, 88, 96, 104, 112, 120);
    run_case("R5 mode8 count3", 8'h32, 1'b1, 1'b0);
    run_case("R3 found count0", 8'h02, 1'b1, 1'b0);
  endtask

  task automatic t_busy_ignore();
    set_pos(1024, 1025, 1026, 1027, 1028, 1029, 1030, 1031);
    run_case("R8 R9 interference", 8'h82, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fill();
    t_no_errors();
    t_uncorrectable();
    t_mode4();
    t_mode8();
    t_busy_ignore();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule